// File: doc/BRIEF.md
# In-Order Write Completion Tracker

This block sits beside the write side of a receive DMA engine. Every packet that lands in memory starts with a free descriptor pointer fetched from a free queue. The tracker gives that packet a slot and an ID. It counts the memory writes issued under that ID and retires them as their write responses come back. The descriptor pointer goes back out toward the completion queue only when the last write of the packet has been issued and every response for it has arrived.

The memory system may acknowledge writes in any order, but the pointers leave strictly in the order in which the packets were allocated. A finished packet therefore waits behind any older packet that is still busy. An error status on any write response of a packet is latched in its slot and travels out with its pointer.

Only channels that hand descriptors over by reference use the tracker. An allocation flagged as coming from any other channel takes no slot and produces no pointer.

Top module: `wr_order_tracker`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rel_valid` is 0, `alloc_ready` is 1 and `alloc_id` is 0.
- R2: Slots are handed out as IDs 0,1,...,DEPTH-1 and then wrap to 0. `alloc_id` shows the ID the next tracked allocation will get. With DEPTH slots occupied, `alloc_ready` is 0, and an `alloc_valid` in that state changes nothing.
- R3: For an occupied slot, a write-issue event (`issue_valid` with `issue_id`) adds one to its outstanding count, and a write-response event (`resp_valid` with `resp_id`) removes one. An issue and a response for the same slot in the same cycle leave the count unchanged.
- R4: A slot completes only once an issue event with `issue_last`=1 has been seen for it and its outstanding count is zero. If the oldest slot completes on clock edge E, `rel_valid` is 1 in the cycle after edge E+1.
- R5: Pointers leave on `rel_ptr` in allocation order, whatever order the slots complete in. A completed younger slot waits until every older slot has left.
- R6: A response with `resp_err`=1 marks its slot, and `rel_err` is 1 when that slot's pointer leaves. Otherwise `rel_err` is 0.
- R7: An allocation with `alloc_byref`=0 takes no slot. It leaves `alloc_id` unchanged and produces no release.
- R8: Issue and response events that name an unoccupied slot have no effect on the state that slot has once it is next allocated.
- R9: `rel_valid` is a one-cycle pulse per pointer, at most one pointer per cycle. A chain of completed slots drains on consecutive cycles, and each freed slot can be allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | Allocate a slot for a newly fetched descriptor |
| alloc_byref | input | 1 | 1: the channel hands descriptors over by reference (tracked); 0: bypass |
| alloc_ptr | input | PTR_W | Descriptor pointer of the new packet |
| alloc_ready | output | 1 | A free slot exists |
| alloc_id | output | ID_W | ID the next tracked allocation receives |
| issue_valid | input | 1 | A memory write was issued |
| issue_id | input | ID_W | Packet ID of the issued write |
| issue_last | input | 1 | This is the final write of the packet |
| resp_valid | input | 1 | A write response returned |
| resp_id | input | ID_W | Packet ID of the response |
| resp_err | input | 1 | Response carried an error status |
| rel_valid | output | 1 | Pointer release pulse |
| rel_ptr | output | PTR_W | Released descriptor pointer |
| rel_err | output | 1 | Released packet saw an error response |

## Verification
A slot count that drifts shows up as a packet that never leaves, or as one that leaves early. An early release appears two edges after the count wrongly reaches zero. A lost release stalls every younger pointer, so the scoreboard sees the missing pointer at the next expected release or in the final drain. A head index that steps wrongly shows up as a pointer out of order, or as a repeated one, on the very next release. A broken allocation index is visible at once on `alloc_id` and leaves the `alloc_ready` level wrong once the table fills.

// File: rtl/wot_pkg.sv
package wot_pkg;

  // Net change applied to one slot's outstanding-write count in a cycle.
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_UP   = 2'd1,
    CNT_DOWN = 2'd2
  } cnt_op_e;

  function automatic cnt_op_e cnt_op(input logic inc, input logic dec);
    if (inc && !dec)      return CNT_UP;
    else if (dec && !inc) return CNT_DOWN;
    else                  return CNT_HOLD;
  endfunction

endpackage

// File: rtl/wot_ring.sv
module wot_ring #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3,
  parameter int OCC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_fire,
  input  logic             retire,
  output logic [ID_W-1:0]  head,
  output logic [ID_W-1:0]  tail,
  output logic [OCC_W-1:0] occ,
  output logic             full
);

  localparam logic [ID_W-1:0]  LAST_IDX = ID_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] OCC_MAX  = OCC_W'(DEPTH);

  logic [ID_W-1:0] head_nxt;
  logic [ID_W-1:0] tail_nxt;

  always_comb begin
    head_nxt = (head == LAST_IDX) ? '0 : head + 1'b1;
    tail_nxt = (tail == LAST_IDX) ? '0 : tail + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      if (retire)     head <= head_nxt;
      if (alloc_fire) tail <= tail_nxt;
      case ({alloc_fire, retire})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign full = (occ == OCC_MAX);

endmodule

// File: rtl/wot_ptr_mem.sv
module wot_ptr_mem #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3,
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [ID_W-1:0]  wr_idx,
  input  logic [PTR_W-1:0] wr_data,
  input  logic [ID_W-1:0]  rd_idx,
  output logic [PTR_W-1:0] rd_data
);

  // Simple dual-port array with no reset: maps onto distributed RAM.
  logic [PTR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/wot_slot_bank.sv
module wot_slot_bank
  import wot_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3,
  parameter int CNT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_fire,
  input  logic [ID_W-1:0] alloc_idx,
  input  logic            retire,
  input  logic [ID_W-1:0] head,
  input  logic            issue_valid,
  input  logic [ID_W-1:0] issue_id,
  input  logic            issue_last,
  input  logic            resp_valid,
  input  logic [ID_W-1:0] resp_id,
  input  logic            resp_err,
  output logic            head_done,
  output logic            head_err
);

  logic [DEPTH-1:0] busy;
  logic [DEPTH-1:0] issued_all;
  logic [DEPTH-1:0] err_seen;
  logic [DEPTH-1:0] cnt_zero;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [ID_W-1:0] MY_ID = ID_W'(i);

    logic [CNT_W-1:0] cnt;
    logic             inc;
    logic             dec;

    assign inc = issue_valid && (issue_id == MY_ID);
    assign dec = resp_valid && (resp_id == MY_ID);

    always_ff @(posedge clk) begin
      if (rst) begin
        busy[i]       <= 1'b0;
        issued_all[i] <= 1'b0;
        err_seen[i]   <= 1'b0;
        cnt           <= '0;
      end else if (alloc_fire && alloc_idx == MY_ID) begin
        busy[i]       <= 1'b1;
        issued_all[i] <= 1'b0;
        err_seen[i]   <= 1'b0;
        cnt           <= '0;
      end else if (retire && head == MY_ID) begin
        busy[i]       <= 1'b0;
      end else if (busy[i]) begin
        unique case (cnt_op(inc, dec))
          CNT_UP:   cnt <= cnt + 1'b1;
          CNT_DOWN: cnt <= cnt - 1'b1;
          default:  cnt <= cnt;
        endcase
        if (inc && issue_last) issued_all[i] <= 1'b1;
        if (dec && resp_err)   err_seen[i]   <= 1'b1;
      end
    end

    assign cnt_zero[i] = (cnt == '0);
  end

  assign head_done = busy[head] && issued_all[head] && cnt_zero[head];
  assign head_err  = err_seen[head];

endmodule

// File: rtl/wr_order_tracker.sv
module wr_order_tracker #(
  parameter int PTR_W = 32,
  parameter int DEPTH = 8,
  parameter int CNT_W = 8,
  localparam int ID_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_valid,
  input  logic             alloc_byref,
  input  logic [PTR_W-1:0] alloc_ptr,
  output logic             alloc_ready,
  output logic [ID_W-1:0]  alloc_id,
  input  logic             issue_valid,
  input  logic [ID_W-1:0]  issue_id,
  input  logic             issue_last,
  input  logic             resp_valid,
  input  logic [ID_W-1:0]  resp_id,
  input  logic             resp_err,
  output logic             rel_valid,
  output logic [PTR_W-1:0] rel_ptr,
  output logic             rel_err
);

  logic             alloc_fire;
  logic             retire;
  logic             full;
  logic [ID_W-1:0]  head;
  logic [ID_W-1:0]  tail;
  logic [OCC_W-1:0] occ;
  logic             head_done;
  logic             head_err;
  logic [PTR_W-1:0] head_ptr;

  assign alloc_ready = !full;
  assign alloc_id    = tail;
  assign alloc_fire  = alloc_valid && alloc_byref && !full;
  assign retire      = head_done;

  wot_ring #(.DEPTH(DEPTH), .ID_W(ID_W), .OCC_W(OCC_W)) u_ring (
    .clk        (clk),
    .rst        (rst),
    .alloc_fire (alloc_fire),
    .retire     (retire),
    .head       (head),
    .tail       (tail),
    .occ        (occ),
    .full       (full)
  );

  wot_ptr_mem #(.DEPTH(DEPTH), .ID_W(ID_W), .PTR_W(PTR_W)) u_mem (
    .clk     (clk),
    .wr_en   (alloc_fire),
    .wr_idx  (tail),
    .wr_data (alloc_ptr),
    .rd_idx  (head),
    .rd_data (head_ptr)
  );

  wot_slot_bank #(.DEPTH(DEPTH), .ID_W(ID_W), .CNT_W(CNT_W)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .alloc_fire  (alloc_fire),
    .alloc_idx   (tail),
    .retire      (retire),
    .head        (head),
    .issue_valid (issue_valid),
    .issue_id    (issue_id),
    .issue_last  (issue_last),
    .resp_valid  (resp_valid),
    .resp_id     (resp_id),
    .resp_err    (resp_err),
    .head_done   (head_done),
    .head_err    (head_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_valid <= 1'b0;
      rel_ptr   <= '0;
      rel_err   <= 1'b0;
    end else begin
      rel_valid <= retire;
      if (retire) begin
        rel_ptr <= head_ptr;
        rel_err <= head_err;
      end else begin
        rel_err <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wot_checker.sv
module wot_checker #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3,
  parameter int OCC_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_valid,
  input logic             alloc_byref,
  input logic             alloc_ready,
  input logic [ID_W-1:0]  alloc_id,
  input logic             rel_valid,
  input logic [OCC_W-1:0] occ
);

  localparam logic [ID_W-1:0] TOP_ID = ID_W'(DEPTH - 1);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!rel_valid && alloc_ready && alloc_id == '0)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(DEPTH)); // R2

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    !alloc_ready |=> $stable(alloc_id)); // R2

  AST_ID_STEPS: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && alloc_byref && alloc_ready) |=>
      alloc_id == (($past(alloc_id) == TOP_ID) ? '0 : $past(alloc_id) + 1'b1)); // R2

  AST_BYPASS_NO_SLOT: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && !alloc_byref) |=> $stable(alloc_id)); // R7

  AST_REL_HAS_SLOT: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> $past(occ) != '0); // R9

  AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (occ + 1'b1) >= $past(occ)); // R9

endmodule

bind wr_order_tracker wot_checker #(.DEPTH(DEPTH), .ID_W(ID_W), .OCC_W(OCC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .alloc_valid (alloc_valid),
  .alloc_byref (alloc_byref),
  .alloc_ready (alloc_ready),
  .alloc_id    (alloc_id),
  .rel_valid   (rel_valid),
  .occ         (occ)
);

// File: tb/wr_order_tracker_test.sv
`timescale 1ns/1ps
module wr_order_tracker_test;

  localparam int PTR_W = 32;
  localparam int DEPTH = 8;
  localparam int ID_W  = 3;

  logic             clk = 1'b0;
  logic             rst;
  logic             alloc_valid, alloc_byref;
  logic [PTR_W-1:0] alloc_ptr;
  logic             alloc_ready;
  logic [ID_W-1:0]  alloc_id;
  logic             issue_valid, issue_last;
  logic [ID_W-1:0]  issue_id;
  logic             resp_valid, resp_err;
  logic [ID_W-1:0]  resp_id;
  logic             rel_valid, rel_err;
  logic [PTR_W-1:0] rel_ptr;

  int total = 0;
  int bad   = 0;
  logic [PTR_W:0] exp_q[$];
  logic [PTR_W:0] mon_e;
  logic [ID_W-1:0] ids[DEPTH];
  logic [ID_W-1:0] tmp_id;
  logic [ID_W-1:0] held_id;

  always #2 clk = ~clk;

  wr_order_tracker #(.PTR_W(PTR_W), .DEPTH(DEPTH), .CNT_W(8)) uut (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_byref(alloc_byref), .alloc_ptr(alloc_ptr),
    .alloc_ready(alloc_ready), .alloc_id(alloc_id),
    .issue_valid(issue_valid), .issue_id(issue_id), .issue_last(issue_last),
    .resp_valid(resp_valid), .resp_id(resp_id), .resp_err(resp_err),
    .rel_valid(rel_valid), .rel_ptr(rel_ptr), .rel_err(rel_err)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: allocates a tracked slot and records the expected release.
  task automatic do_alloc(input logic [PTR_W-1:0] p, input bit er,
                          output logic [ID_W-1:0] id);
    while (!alloc_ready) step();
    id = alloc_id;
    alloc_valid = 1'b1; alloc_byref = 1'b1; alloc_ptr = p;
    exp_q.push_back({er, p});
    step();
    alloc_valid = 1'b0;
  endtask

  task automatic drive_ev(input bit iv, input logic [ID_W-1:0] iid, input bit il,
                          input bit rv, input logic [ID_W-1:0] rid, input bit re);
    issue_valid = iv; issue_id = iid; issue_last = il;
    resp_valid  = rv; resp_id  = rid; resp_err   = re;
    step();
    issue_valid = 1'b0; resp_valid = 1'b0; issue_last = 1'b0; resp_err = 1'b0;
  endtask

  task automatic issue(input logic [ID_W-1:0] id, input bit last);
    drive_ev(1'b1, id, last, 1'b0, '0, 1'b0);
  endtask

  task automatic resp(input logic [ID_W-1:0] id, input bit er);
    drive_ev(1'b0, '0, 1'b0, 1'b1, id, er);
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 30 && exp_q.size() != 0; k++) step();
    chk(exp_q.size() == 0, req, "pending releases after drain", exp_q.size(), 0);
  endtask

  // Monitor: pops the scoreboard on every release pulse.
  always @(negedge clk) begin
    if (rst === 1'b0 && rel_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "release with nothing expected", {31'b0, rel_err, rel_ptr}, 0);
      end else begin
        mon_e = exp_q.pop_front();
        chk({rel_err, rel_ptr} == mon_e, "R5 R6", "released {err,ptr}",
            {31'b0, rel_err, rel_ptr}, {31'b0, mon_e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    alloc_valid = 1'b0; alloc_byref = 1'b1; alloc_ptr = '0;
    issue_valid = 1'b0; issue_id = '0; issue_last = 1'b0;
    resp_valid = 1'b0; resp_id = '0; resp_err = 1'b0;
    repeat (3) step();
    chk(rel_valid == 1'b0, "R1", "rel_valid in reset", rel_valid, 0);
    rst = 1'b0;
    step();
    chk(alloc_ready == 1'b1, "R1", "alloc_ready after reset", alloc_ready, 1);
    chk(alloc_id == '0, "R1", "alloc_id after reset", alloc_id, 0);
    chk(rel_valid == 1'b0, "R1", "rel_valid after reset", rel_valid, 0);

    // R4: release waits for issue_last and every response; exact latency
    do_alloc(32'hA000_0000, 1'b0, tmp_id);
    chk(tmp_id == 3'd0, "R2", "first id", tmp_id, 0);
    issue(tmp_id, 1'b0); issue(tmp_id, 1'b0); issue(tmp_id, 1'b1);
    resp(tmp_id, 1'b0); resp(tmp_id, 1'b0);
    repeat (5) step();
    chk(exp_q.size() == 1, "R4", "held with one response missing", exp_q.size(), 1);
    resp(tmp_id, 1'b0);
    chk(rel_valid == 1'b0, "R4", "rel_valid one edge after completion", rel_valid, 0);
    step();
    chk(rel_valid == 1'b1, "R4", "rel_valid two edges after completion", rel_valid, 1);
    drain("R4");

    // R5: younger slots complete first, oldest last
    do_alloc(32'hB000_0001, 1'b0, ids[0]);
    do_alloc(32'hC000_0002, 1'b0, ids[1]);
    do_alloc(32'hD000_0003, 1'b0, ids[2]);
    chk(ids[2] == 3'd3, "R2", "ids in fetch order", ids[2], 3);
    issue(ids[2], 1'b1); resp(ids[2], 1'b0);
    issue(ids[1], 1'b0); issue(ids[1], 1'b1);
    resp(ids[1], 1'b0); resp(ids[1], 1'b0);
    issue(ids[0], 1'b1);
    repeat (4) step();
    chk(exp_q.size() == 3, "R5", "younger complete slots wait", exp_q.size(), 3);
    resp(ids[0], 1'b0);
    drain("R5");

    // R3: simultaneous issue and response on one slot keep the count
    do_alloc(32'hE000_0004, 1'b0, tmp_id);
    issue(tmp_id, 1'b0);
    drive_ev(1'b1, tmp_id, 1'b1, 1'b1, tmp_id, 1'b0);
    repeat (4) step();
    chk(exp_q.size() == 1, "R3", "one write still outstanding", exp_q.size(), 1);
    resp(tmp_id, 1'b0);
    drain("R3");

    // R6: error status on one response travels with the pointer
    do_alloc(32'hF000_0005, 1'b1, tmp_id);
    issue(tmp_id, 1'b0); issue(tmp_id, 1'b1);
    resp(tmp_id, 1'b1); resp(tmp_id, 1'b0);
    drain("R6");

    // R7: a bypass allocation takes no slot
    held_id = alloc_id;
    alloc_valid = 1'b1; alloc_byref = 1'b0; alloc_ptr = 32'h7777_7777;
    step();
    alloc_valid = 1'b0; alloc_byref = 1'b1;
    step();
    chk(alloc_id == held_id, "R7", "alloc_id after bypass", alloc_id, held_id);
    repeat (4) step();
    chk(exp_q.size() == 0, "R7", "bypass produced no release", exp_q.size(), 0);

    // R8: events aimed at a free slot do not leak into its next use
    held_id = alloc_id;
    issue(held_id, 1'b0); issue(held_id, 1'b0); resp(held_id, 1'b1);
    do_alloc(32'h1234_5678, 1'b0, tmp_id);
    chk(tmp_id == held_id, "R8", "slot reused", tmp_id, held_id);
    issue(tmp_id, 1'b1); resp(tmp_id, 1'b0);
    drain("R8");

    // R2 and R9: fill the table, block, complete in reverse, drain back to back
    for (int k = 0; k < DEPTH; k++) do_alloc(32'h5000_0000 + k, 1'b0, ids[k]);
    step();
    chk(alloc_ready == 1'b0, "R2", "alloc_ready when full", alloc_ready, 0);
    held_id = alloc_id;
    alloc_valid = 1'b1; alloc_byref = 1'b1; alloc_ptr = 32'hDEAD_BEEF;
    step();
    alloc_valid = 1'b0;
    step();
    chk(alloc_id == held_id, "R2", "alloc_id while full", alloc_id, held_id);
    for (int k = DEPTH - 1; k > 0; k--) begin
      issue(ids[k], 1'b1); resp(ids[k], 1'b0);
    end
    issue(ids[0], 1'b1); resp(ids[0], 1'b0);
    step();
    for (int k = 0; k < DEPTH; k++) begin
      chk(rel_valid == 1'b1, "R9", "back-to-back release", rel_valid, 1);
      step();
    end
    chk(rel_valid == 1'b0, "R9", "pulse train ends", rel_valid, 0);
    chk(alloc_ready == 1'b1, "R9", "slots free again", alloc_ready, 1);
    drain("R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule